// File: doc/BRIEF.md
# Binary Field Polynomial-Basis Multiplier

This block multiplies two elements of the binary extension field GF(2^K) and returns the product as a K-bit field element. Every word is a coefficient vector in polynomial basis: bit i holds the coefficient of α^i, where α is a root of a fixed irreducible polynomial P(x). The block is purely combinational. It has no clock, no reset and no storage, and the result follows the operands directly.

The block works in two stages. A carry-free product stage forms the 2K-1 coefficients of the plain polynomial product. Each coefficient is the XOR of the AND terms a_i·b_j whose indices add up to that coefficient's index. A folding stage then maps each high coefficient (index K or above) onto the K output bits. It uses the residue of α^n modulo P. This fold map is computed from the polynomial parameter at elaboration time, so every output bit is a fixed XOR of product coefficients and no division is done at run time.

The width and the polynomial are parameters. The polynomial parameter has K+1 bits, and bit i is the coefficient of x^i. A configuration is rejected during elaboration in any of these cases: the top bit of the polynomial is clear, the constant bit is zero, or K lies outside 2..32.

Top module: `gf_mastrovito_mul`

## Requirements
- R1: Operands and result use polynomial basis with bit i as the coefficient of α^i. For example, 1·α gives 4'b0010 in the default field.
- R2: The intermediate product is carry-free: coefficient n is the XOR of a_i AND b_j over all i+j=n. For example, (α+1)·(α+1) gives α^2+1 (4'b0101), not 4'b1001.
- R3: With the defaults K=4 and POLY=5'b11001 (x^4+x^3+1), z equals A·B mod P(x) for all 256 operand pairs.
- R4: When the degrees of the two operands add up to less than K, no folding happens and z equals the plain carry-free product. For example, 4'b0011·4'b0101 gives 4'b1111.
- R5: In the default field, α^4 folds to α^3+1 (4'b1001), α^5 folds to α^3+α+1 (4'b1011), and α^6 folds to α^3+α^2+α+1 (4'b1111).
- R6: Multiplying by the unit element 1 (value 1) on either side returns the other operand unchanged.
- R7: Multiplying by 0 on either side gives 0.
- R8: The result does not depend on operand order: a·b equals b·a.
- R9: With K=2 and POLY=3'b111 (x^2+x+1), z0 = a0b0 ^ a1b1 and z1 = a0b1 ^ a1b0 ^ a1b1 for all 16 operand pairs.
- R10: The output settles after an operand change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | K | First operand, polynomial-basis coefficients |
| b | input | K | Second operand, polynomial-basis coefficients |
| z | output | K | Product a·b reduced modulo the field polynomial |

## Verification
The embedded checks are immediate assertions evaluated inside combinational processes. They assume that the operands are fully driven with known 0/1 values, and each check is skipped while any bit it reads is unknown. The bench drives both operands to known values at time zero and changes them only between sampling points. It waits a short settling delay before each comparison, so the assertions never see a half-updated operand pair. The only configurations exercised are the default field and the two-bit field, both of which pass the elaboration-time parameter rules.

// File: rtl/gf_mul_pkg.sv
package gf_mul_pkg;

   // Upper bound on the field width supported by the constant functions.
   localparam int GF_MAX_K = 32;

   // Returns a mask over product indices 0..2k-2. Bit n of the mask is set
   // when the residue of alpha^n modulo poly has a 1 in coefficient j.
   function automatic logic [63:0] fold_column(int k, logic [63:0] poly, int j);
      logic [63:0] resid;
      logic [63:0] keep;
      logic [63:0] col;
      logic        carry;
      keep  = (64'd1 << k) - 64'd1;
      resid = 64'd1;
      col   = '0;
      for (int n = 0; n < 2 * k - 1; n++) begin
         if (resid[j]) col[n] = 1'b1;
         carry = resid[k-1];
         resid = (resid << 1) & keep;
         if (carry) resid = resid ^ (poly & keep);
      end
      return col;
   endfunction

endpackage

// File: rtl/gf_clmul.sv
module gf_clmul #(
   parameter int K = 4,
   localparam int W = 2 * K - 1
) (
   input  logic [K-1:0] a,
   input  logic [K-1:0] b,
   output logic [W-1:0] s
);

   for (genvar n = 0; n < W; n++) begin : g_coef
      logic [K-1:0] terms;
      for (genvar i = 0; i < K; i++) begin : g_term
         if ((n - i >= 0) && (n - i < K)) begin : g_live
            assign terms[i] = a[i] & b[n-i];
         end else begin : g_dead
            assign terms[i] = 1'b0;
         end
      end
      assign s[n] = ^terms;
   end

   // Evaluating at x=1: the parity of the product equals the product of the
   // operand parities.
   always_comb begin
      if (!$isunknown({a, b, s})) begin
         p_parity_r2: assert ((^s) == ((^a) & (^b)))
            else $error("carry-free product parity mismatch");
      end
   end

endmodule

// File: rtl/gf_fold.sv
module gf_fold #(
   parameter int         K    = 4,
   parameter logic [K:0] POLY = 5'b11001,
   localparam int        W    = 2 * K - 1
) (
   input  logic [W-1:0] s,
   output logic [K-1:0] z
);

   for (genvar j = 0; j < K; j++) begin : g_out
      localparam logic [63:0] FULL = gf_mul_pkg::fold_column(K, 64'(POLY), j);
      localparam logic [W-1:0] COL = FULL[W-1:0];
      assign z[j] = ^(s & COL);
   end

   // With no coefficient at or above x^K, folding must leave the low part as is.
   always_comb begin
      if (!$isunknown({s, z}) && (s[W-1:K] == '0)) begin
         p_low_pass_r4: assert (z == s[K-1:0])
            else $error("fold altered an already reduced product");
      end
   end

endmodule

// File: rtl/gf_mastrovito_mul.sv
module gf_mastrovito_mul #(
   parameter int         K    = 4,
   parameter logic [K:0] POLY = 5'b11001
) (
   input  logic [K-1:0] a,
   input  logic [K-1:0] b,
   output logic [K-1:0] z
);

   localparam int          W    = 2 * K - 1;
   localparam logic [K-1:0] ONE = {{(K-1){1'b0}}, 1'b1};

   if (K < 2 || K > gf_mul_pkg::GF_MAX_K) begin : g_bad_width
      $error("field width K out of supported range");
   end
   if (POLY[K] != 1'b1) begin : g_bad_top
      $error("field polynomial must have its x^K coefficient set");
   end
   if (POLY[0] != 1'b1) begin : g_bad_const
      $error("field polynomial must have a nonzero constant term");
   end

   logic [W-1:0] prod;

   gf_clmul #(.K(K)) u_clmul (
      .a (a),
      .b (b),
      .s (prod)
   );

   gf_fold #(.K(K), .POLY(POLY)) u_fold (
      .s (prod),
      .z (z)
   );

   always_comb begin
      if (!$isunknown({a, b, z})) begin
         if (b == ONE) begin
            p_unit_right_r6: assert (z == a) else $error("a*1 != a");
         end
         if (a == ONE) begin
            p_unit_left_r6: assert (z == b) else $error("1*b != b");
         end
         if (a == '0 || b == '0) begin
            p_zero_r7: assert (z == '0) else $error("product with zero not zero");
         end
      end
   end

endmodule

// File: tb/gf_mastrovito_mul_bench.sv
module gf_mastrovito_mul_bench;

   logic       clk = 1'b0;
   int         cyc = 0;
   int         errors = 0;
   int         checks = 0;

   logic [3:0] a4 = '0;
   logic [3:0] b4 = '0;
   logic [3:0] z4;
   logic [1:0] a2 = '0;
   logic [1:0] b2 = '0;
   logic [1:0] z2;

   always #10 clk = ~clk;

   gf_mastrovito_mul #(.K(4), .POLY(5'b11001)) u_gf_mastrovito_mul (
      .a (a4), .b (b4), .z (z4)
   );

   gf_mastrovito_mul #(.K(2), .POLY(3'b111)) u_gf_mastrovito_mul_k2 (
      .a (a2), .b (b2), .z (z2)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 100000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: act=%0d exp=%0d", cyc, 100000);
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   function automatic int ref_mul(int k, int poly, int x, int y);
      int acc = 0;
      int sh  = x;
      for (int i = 0; i < k; i++) begin
         if (y[i]) acc = acc ^ sh;
         sh = sh << 1;
         if (sh[k]) sh = sh ^ poly;
      end
      return acc;
   endfunction

   task automatic check(string req, int act, int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic drive4(int x, int y);
      @(negedge clk);
      a4 = 4'(x);
      b4 = 4'(y);
      #1;
   endtask

   task automatic t_idle_state;
      drive4(0, 0);
      check("R7 idle", int'(z4), 0);
   endtask

   task automatic t_basis;
      drive4(1, 2);
      check("R1 alpha", int'(z4), 4'b0010);
      drive4(2, 2);
      check("R1 alpha^2", int'(z4), 4'b0100);
   endtask

   task automatic t_carry_free;
      drive4(3, 3);
      check("R2 no carry", int'(z4), 4'b0101);
      drive4(7, 3);
      check("R2 no carry", int'(z4), 4'b1001);
   endtask

   task automatic t_exhaustive;
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            drive4(x, y);
            check("R3 exhaustive", int'(z4), ref_mul(4, 5'b11001, x, y));
         end
      end
   endtask

   task automatic t_low_pass;
      drive4(3, 5);
      check("R4 no fold", int'(z4), 4'b1111);
      drive4(6, 2);
      check("R4 no fold", int'(z4), 4'b1100);
   endtask

   task automatic t_fold_map;
      drive4(2, 8);
      check("R5 alpha^4", int'(z4), 4'b1001);
      drive4(4, 8);
      check("R5 alpha^5", int'(z4), 4'b1011);
      drive4(8, 8);
      check("R5 alpha^6", int'(z4), 4'b1111);
   endtask

   task automatic t_unit;
      for (int x = 0; x < 16; x++) begin
         drive4(x, 1);
         check("R6 a*1", int'(z4), x);
         drive4(1, x);
         check("R6 1*b", int'(z4), x);
      end
   endtask

   task automatic t_zero;
      for (int x = 0; x < 16; x++) begin
         drive4(x, 0);
         check("R7 a*0", int'(z4), 0);
         drive4(0, x);
         check("R7 0*b", int'(z4), 0);
      end
   endtask

   task automatic t_commute;
      int fwd;
      for (int x = 0; x < 16; x++) begin
         for (int y = x + 1; y < 16; y++) begin
            drive4(x, y);
            fwd = int'(z4);
            drive4(y, x);
            check("R8 commute", int'(z4), fwd);
         end
      end
   endtask

   task automatic t_two_bit;
      int e0;
      int e1;
      for (int x = 0; x < 4; x++) begin
         for (int y = 0; y < 4; y++) begin
            @(negedge clk);
            a2 = 2'(x);
            b2 = 2'(y);
            #1;
            e0 = (x & y & 1) ^ ((x >> 1) & (y >> 1) & 1);
            e1 = (x & (y >> 1) & 1) ^ ((x >> 1) & y & 1) ^ ((x >> 1) & (y >> 1) & 1);
            check("R9 k2", int'(z2), (e1 << 1) | e0);
         end
      end
   endtask

   task automatic t_no_clock;
      @(posedge clk);
      #2;
      a4 = 4'd9;
      b4 = 4'd6;
      #1;
      check("R10 comb", int'(z4), ref_mul(4, 5'b11001, 9, 6));
      a4 = 4'd13;
      #1;
      check("R10 comb", int'(z4), ref_mul(4, 5'b11001, 13, 6));
   endtask

   initial begin
      t_idle_state();
      t_basis();
      t_carry_free();
      t_exhaustive();
      t_low_pass();
      t_fold_map();
      t_unit();
      t_zero();
      t_commute();
      t_two_bit();
      t_no_clock();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule